// File: doc/BRIEF.md
# Two-Stage Subsystem Clock Divider with Reset Sequencing

This block derives a slower subsystem clock from the fast engine clock it runs on. The division ratio is the product of two small fields, one per counter stage, so the divided period is (B + 1) × (A + 1) source cycles. The divider has its own hold bit in the control register, separate from core reset. An enable bit gates the output. After any change to the ratio, the enable takes effect only once software has read the register back.

The same register drives two domain reset outputs. The bus-domain reset follows its release bit directly. The phy-domain reset also waits until the divided clock has produced a fixed number of ticks. A build-in self-test start pulse is issued on the rising edge of a control bit, and a done input is reported in the read data. Access is through one register with a write strobe, a read strobe and combinational read data.

Top module: `subclk_seq`

## Requirements
- R1: The divided period is (B+1)*(A+1) source cycles. A is write bits [2:0]. B is bits [4:3].
- R2: After the divider starts, output `divClk` is high for the first ceil(N/2) cycles of each N-cycle period and low for the rest. `divTick` is high only in the first cycle of each period. The first period begins in the cycle after the starting write.
- R3: While the run bit [5] is 0, or core reset is active, the divider stage counters are held at zero and both clock outputs are low. Releasing the bit starts a fresh period at phase zero.
- R4: While the enable bit [6] is 0, `divClk` and `divTick` stay low even though the divider keeps counting.
- R5: A write that changes a ratio field raises an internal pending flag. While the flag is set, the enable is not honoured and both clock outputs stay low. A single `rdEn` strobe clears the flag.
- R6: `busRstN` equals the bus-release bit [7]. It is visible in the cycle after the write.
- R7: `phyRstN` goes high only when the phy-release bit [8] is 1 and SETTLE_TICKS (default 6) enabled divider ticks have been counted since core reset. It follows one cycle after both conditions hold. The tick count is cleared only by core reset. A bit written early defers the release until the count completes.
- R8: A write that would change a ratio field while the stored run bit is 1 leaves both ratio fields unchanged and sets the sticky error bit [10]. A write with bit [10] = 1 clears the error bit, unless that same write is itself rejected.
- R9: Bit [4], the upper bit of B, is not implemented and always reads 0, so the ratio is at most 16. All other written fields read back as written. Read bit [11] mirrors the `bistDone` input.
- R10: `bistStart` is high for exactly one cycle, the cycle after a write that takes bit [9] from 0 to 1. Writing 1 when the bit is already 1 gives no pulse.
- R11: After core reset, every register field reads 0 and `divClk`, `divTick`, `busRstN`, `phyRstN` and `bistStart` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine (source) clock |
| rstN | input | 1 | Core reset, active low, asynchronous |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 11 | Write data for bits [10:0] |
| rdEn | input | 1 | Read strobe; counts as the read-back after a ratio change |
| rdData | output | 12 | Register contents; combinational |
| bistDone | input | 1 | Self-test completion, reported in read bit [11] |
| divClk | output | 1 | Divided, gated subsystem clock level |
| divTick | output | 1 | One-cycle pulse at the start of each divided period |
| busRstN | output | 1 | Bus-domain reset, active low |
| phyRstN | output | 1 | Phy-domain reset, active low |
| bistStart | output | 1 | Single-cycle self-test start request |

## Verification
A stage counter that wraps at the wrong value shows up within one divided period. It would stretch or shorten the gap between `divTick` pulses and move the falling edge of `divClk`. The bench therefore compares every cycle of two full periods for all sixteen implemented ratio settings. A wrong tick count or a lost pending flag is only visible at `phyRstN` or at the clock outputs. For that reason the bench checks the exact release cycle and watches the outputs stay low across the gap before the read-back. A bad ratio-protection decision shows at the next read of the register.

// File: rtl/subclk_pkg.sv
package subclk_pkg;

  // Stage widths; only DIV_B_IMPL bits of stage B are stored.
  localparam int DIV_A_W    = 3;
  localparam int DIV_B_W    = 2;
  localparam int DIV_B_IMPL = 1;

  // Register bit positions.
  localparam int F_A_LO  = 0;
  localparam int F_B_LO  = F_A_LO + DIV_A_W;
  localparam int F_RUN   = F_B_LO + DIV_B_W;
  localparam int F_EN    = F_RUN + 1;
  localparam int F_BUS   = F_EN + 1;
  localparam int F_PHY   = F_BUS + 1;
  localparam int F_BIST  = F_PHY + 1;
  localparam int F_ERR   = F_BIST + 1;
  localparam int F_DONE  = F_ERR + 1;
  localparam int REG_W   = F_DONE + 1;
  localparam int WR_W    = F_DONE;      // done bit is read-only

  // Position counter must hold the largest product plus one.
  localparam int POS_W   = DIV_A_W + DIV_B_W + 1;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic               run;
    logic               gateOn;
    logic [DIV_A_W-1:0] ratioA;
    logic [DIV_B_W-1:0] ratioB;
  } divCtrl_t;

endpackage

// File: rtl/subclk_div.sv
module subclk_div
  import subclk_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  divCtrl_t ctrl,
  output logic     divClk,
  output logic     divTick
);

  logic [DIV_A_W-1:0] cntA;
  logic [DIV_B_W-1:0] cntB;
  logic [POS_W-1:0]   spanA;
  logic [POS_W-1:0]   period;
  logic [POS_W-1:0]   highLen;
  logic [POS_W-1:0]   pos;
  logic               wrapA;
  logic               wrapB;

  assign wrapA = (cntA == ctrl.ratioA);
  assign wrapB = (cntB == ctrl.ratioB);

  // Two nested stages: A counts every cycle, B advances when A wraps.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntA <= '0;
      cntB <= '0;
    end else if (!ctrl.run) begin
      cntA <= '0;
      cntB <= '0;
    end else if (wrapA) begin
      cntA <= '0;
      cntB <= wrapB ? '0 : cntB + 1'b1;
    end else begin
      cntA <= cntA + 1'b1;
    end
  end

  // Linear phase inside the period, used for the duty-cycle split.
  always_comb begin
    spanA   = POS_W'(ctrl.ratioA) + POS_W'(1);
    period  = spanA * (POS_W'(ctrl.ratioB) + POS_W'(1));
    highLen = (period + POS_W'(1)) >> 1;
    pos     = POS_W'(cntB) * spanA + POS_W'(cntA);
  end

  assign divClk  = ctrl.run && ctrl.gateOn && (pos < highLen);
  assign divTick = ctrl.run && ctrl.gateOn && (pos == '0);

  // R3: a held divider restarts from phase zero.
  p_hold_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.run |=> (cntA == '0 && cntB == '0));

  // R1: stage counters never pass their configured limits.
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cntA <= ctrl.ratioA) && (cntB <= ctrl.ratioB));

endmodule

// File: rtl/subclk_ctrl.sv
module subclk_ctrl
  import subclk_pkg::*;
#(
  parameter int SETTLE_TICKS = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WR_W-1:0]  wrData,
  input  logic             rdEn,
  input  logic             bistDone,
  input  logic             divTick,
  output divCtrl_t         ctrl,
  output logic [REG_W-1:0] rdData,
  output logic             busRstN,
  output logic             phyRstN,
  output logic             bistStart
);

  localparam int WAIT_W = $clog2(SETTLE_TICKS + 1);

  logic [DIV_A_W-1:0]    ratioAQ;
  logic [DIV_B_IMPL-1:0] ratioBQ;
  logic [DIV_B_W-1:0]    ratioBFull;
  logic runQ, enQ, busQ, phyQ, bistQ, errQ, pendQ;
  logic phyRstQ, bistPulseQ;
  logic [WAIT_W-1:0]     waitCnt;
  logic                  waitDone;

  logic [DIV_A_W-1:0] wrA;
  logic [DIV_B_W-1:0] wrB;
  logic               ratioDiff;
  logic               reject;

  assign ratioBFull = DIV_B_W'(ratioBQ);
  assign wrA        = wrData[F_A_LO +: DIV_A_W];
  assign wrB        = wrData[F_B_LO +: DIV_B_W];
  assign ratioDiff  = (wrA != ratioAQ) || (wrB != ratioBFull);
  assign reject     = wrEn && runQ && ratioDiff;
  assign waitDone   = (waitCnt == WAIT_W'(SETTLE_TICKS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ratioAQ    <= '0;
      ratioBQ    <= '0;
      runQ       <= 1'b0;
      enQ        <= 1'b0;
      busQ       <= 1'b0;
      phyQ       <= 1'b0;
      bistQ      <= 1'b0;
      errQ       <= 1'b0;
      pendQ      <= 1'b0;
      phyRstQ    <= 1'b0;
      bistPulseQ <= 1'b0;
      waitCnt    <= '0;
    end else begin
      if (wrEn) begin
        if (!runQ) begin
          ratioAQ <= wrA;
          ratioBQ <= wrB[DIV_B_IMPL-1:0];
        end
        runQ  <= wrData[F_RUN];
        enQ   <= wrData[F_EN];
        busQ  <= wrData[F_BUS];
        phyQ  <= wrData[F_PHY];
        bistQ <= wrData[F_BIST];
      end

      if (reject)
        errQ <= 1'b1;
      else if (wrEn && wrData[F_ERR])
        errQ <= 1'b0;

      if (wrEn && !runQ && ratioDiff)
        pendQ <= 1'b1;
      else if (rdEn)
        pendQ <= 1'b0;

      bistPulseQ <= wrEn && wrData[F_BIST] && !bistQ;

      if (divTick && !waitDone)
        waitCnt <= waitCnt + 1'b1;

      phyRstQ <= phyQ && waitDone;
    end
  end

  always_comb begin
    rdData                      = '0;
    rdData[F_A_LO +: DIV_A_W]   = ratioAQ;
    rdData[F_B_LO +: DIV_B_W]   = ratioBFull;
    rdData[F_RUN]               = runQ;
    rdData[F_EN]                = enQ;
    rdData[F_BUS]               = busQ;
    rdData[F_PHY]               = phyQ;
    rdData[F_BIST]              = bistQ;
    rdData[F_ERR]               = errQ;
    rdData[F_DONE]              = bistDone;
  end

  assign ctrl.run    = runQ;
  assign ctrl.gateOn = enQ && !pendQ;
  assign ctrl.ratioA = ratioAQ;
  assign ctrl.ratioB = ratioBFull;

  assign busRstN   = busQ;
  assign phyRstN   = phyRstQ;
  assign bistStart = bistPulseQ;

  // R8: a rejected ratio write raises the error flag.
  p_err_on_reject_r8: assert property (@(posedge clk) disable iff (!rstN)
    reject |=> errQ);

  // R8: ratio fields cannot move while the divider runs.
  p_ratio_locked_r8: assert property (@(posedge clk) disable iff (!rstN)
    runQ |=> ($stable(ratioAQ) && $stable(ratioBQ)));

  // R10: the start request lasts a single cycle.
  p_bist_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    bistStart |=> !bistStart);

  // R7: phy release never precedes the settle count.
  p_phy_after_settle_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phyRstN) |-> waitDone);

endmodule

// File: rtl/subclk_seq.sv
module subclk_seq
  import subclk_pkg::*;
#(
  parameter int SETTLE_TICKS = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WR_W-1:0]  wrData,
  input  logic             rdEn,
  output logic [REG_W-1:0] rdData,
  input  logic             bistDone,
  output logic             divClk,
  output logic             divTick,
  output logic             busRstN,
  output logic             phyRstN,
  output logic             bistStart
);

  divCtrl_t ctrl;

  subclk_ctrl #(.SETTLE_TICKS(SETTLE_TICKS)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .rdEn      (rdEn),
    .bistDone  (bistDone),
    .divTick   (divTick),
    .ctrl      (ctrl),
    .rdData    (rdData),
    .busRstN   (busRstN),
    .phyRstN   (phyRstN),
    .bistStart (bistStart)
  );

  subclk_div uDiv (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .divClk  (divClk),
    .divTick (divTick)
  );

  // R4: no output clock activity without the enable.
  p_gate_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.gateOn |-> (!divClk && !divTick));

endmodule

// File: tb/sim_subclk_seq.sv
module sim_subclk_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [10:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [11:0] rdData;
  logic        bistDone = 1'b0;
  logic        divClk, divTick, busRstN, phyRstN, bistStart;

  int total = 0;
  int fails = 0;
  int cyc = 0;

  logic [2:0] fa = '0;
  logic [1:0] fb = '0;
  logic frun = 0, fen = 0, fbus = 0, fphy = 0, fbist = 0, ferr = 0;

  always #5 clk = ~clk;

  subclk_seq u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .bistDone(bistDone), .divClk(divClk), .divTick(divTick),
    .busRstN(busRstN), .phyRstN(phyRstN), .bistStart(bistStart)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (time %0t)", req, act, exp, $time);
    end
  endtask

  // Called at a negedge; returns at the negedge after the write edge.
  task automatic put();
    wrData = {ferr, fbist, fphy, fbus, fen, frun, fb, fa};
    wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    ferr = 0;
  endtask

  task automatic readBack();
    rdEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11: reset state
    chk("R11 rdData", rdData, 0);
    chk("R11 divClk", divClk, 0);
    chk("R11 divTick", divTick, 0);
    chk("R11 busRstN", busRstN, 0);
    chk("R11 phyRstN", phyRstN, 0);
    chk("R11 bistStart", bistStart, 0);

    // R9: done input mirrored in bit 11
    bistDone = 1'b1;
    #1 chk("R9 done bit", rdData[11], 1);
    bistDone = 1'b0;
    #1 chk("R9 done bit low", rdData[11], 0);

    // R7: early phy release with ratio 2/1 (N=6)
    fa = 3'd2; fb = 2'd1; fphy = 1; put();
    readBack();
    repeat (4) @(negedge clk);
    chk("R7 held before count", phyRstN, 0);
    frun = 1; fen = 1; put();
    n = 6;
    for (int j = 0; j <= 5 * n + 2; j++) begin
      chk("R2 divClk", divClk, ((j % n) < (n + 1) / 2) ? 1 : 0);
      chk("R2 divTick", divTick, ((j % n) == 0) ? 1 : 0);
      chk("R7 phyRstN timing", phyRstN, (j >= 5 * n + 2) ? 1 : 0);
      @(negedge clk);
    end

    // R6: bus release
    chk("R6 before", busRstN, 0);
    fbus = 1; put();
    chk("R6 released", busRstN, 1);

    // R8: ratio change while running is rejected
    fa = 3'd5; put();
    chk("R8 ratio A kept", rdData[2:0], 2);
    chk("R8 err set", rdData[10], 1);
    fa = 3'd2; ferr = 1; put();
    chk("R8 err cleared", rdData[10], 0);
    chk("R8 ratio A still", rdData[2:0], 2);

    // R7: later release follows one cycle after write
    fphy = 0; put();
    @(negedge clk);
    chk("R7 reasserted", phyRstN, 0);
    fphy = 1; put();
    chk("R7 not yet", phyRstN, 0);
    @(negedge clk);
    chk("R7 one cycle later", phyRstN, 1);

    // R10: bist start pulse
    fbist = 1; put();
    chk("R10 pulse", bistStart, 1);
    @(negedge clk);
    chk("R10 single", bistStart, 0);
    put();
    chk("R10 no pulse on level", bistStart, 0);
    fbist = 0; put();
    chk("R10 no pulse on fall", bistStart, 0);
    fbist = 1; put();
    chk("R10 second pulse", bistStart, 1);

    // R3: stopping forces outputs low at once
    frun = 0; put();
    chk("R3 stopped divClk", divClk, 0);
    chk("R3 stopped divTick", divTick, 0);

    // R9: unimplemented B bit reads 0, others read back
    fa = 3'd0; fb = 2'd3; put();
    chk("R9 B field", rdData[4:3], 1);
    chk("R9 readback", rdData, {1'b0, 1'b0, fbist, fphy, fbus, fen, frun, 2'b01, 3'd0});
    readBack();

    // R5: pending flag blocks the enable until read-back
    fa = 3'd3; fb = 2'd0; put();
    frun = 1; fen = 1; put();
    for (int j = 0; j < 10; j++) begin
      chk("R5 gated divClk", divClk, 0);
      chk("R5 gated divTick", divTick, 0);
      @(negedge clk);
    end
    readBack();
    n = 0;
    for (int j = 0; j < 4; j++) begin
      n += divTick;
      @(negedge clk);
    end
    chk("R5 ticks after read", n, 1);

    // R4: enable off keeps outputs low while running
    fen = 0; put();
    for (int j = 0; j < 10; j++) begin
      chk("R4 divClk off", divClk, 0);
      chk("R4 divTick off", divTick, 0);
      @(negedge clk);
    end

    // R1, R2, R3: sweep every implemented ratio
    for (int b = 0; b < 2; b++) begin
      for (int a = 0; a < 8; a++) begin
        frun = 0; fen = 0; put();
        fa = 3'(a); fb = 2'(b); put();
        readBack();
        chk("R3 held", divClk, 0);
        frun = 1; fen = 1; put();
        n = (a + 1) * (b + 1);
        for (int j = 0; j < 2 * n; j++) begin
          chk("R1 R2 divClk", divClk, ((j % n) < (n + 1) / 2) ? 1 : 0);
          chk("R1 R2 divTick", divTick, ((j % n) == 0) ? 1 : 0);
          @(negedge clk);
        end
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule